// File: doc/BRIEF.md
# Stepper Phase Head-Position Tracker

This block follows the head of a four-coil stepper floppy mechanism. A host touches one of a small set of coil switch addresses by pulsing a strobe with a 4-bit address. Each odd address picks one coil. The block keeps a single "last coil picked" value. It turns each new pick into a signed half-track move of +1, -1 or 0, and applies that move to a clamped head position.

From the head position and a sector position input, the block also forms a linear byte offset into a track-encoded disk image. One track spans two half-tracks and holds a parameterised number of encoded bytes. Picks that switch a coil off, addresses outside the coil range, and any strobe while the drive is offline are all dropped.

Top module: `stepper_head_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, the stored phase (`cur_phase`) is 0 and the head position (`half_track`) is 0, until the first accepted request.
- R2: With `online` high, a strobe with `acc_addr` equal to 1, 3, 5 or 7 sets `cur_phase` to 1, 2, 3 or 4 respectively on the next rising clock edge.
- R3: A strobe with an even `acc_addr` (0, 2, 4, 6) or with `acc_addr` of 8 or more leaves `cur_phase` and `half_track` unchanged.
- R4: A strobe while `online` is low leaves `cur_phase` and `half_track` unchanged.
- R5: When the new phase is the stored phase plus one, with phase 4 wrapping to phase 1, the head position rises by 1.
- R6: When the new phase is the stored phase minus one, with phase 1 wrapping to phase 4, the head position falls by 1.
- R7: A request for the same phase, for the opposite phase (1 and 3, or 2 and 4), or made while the stored phase is 0 does not move the head, but the stored phase is still updated.
- R8: The head position never goes below 0; a backward move at 0 leaves it at 0.
- R9: The head position never exceeds NUM_HT-1 (69 by default); a forward move there leaves it unchanged.
- R10: `img_offset` equals (`half_track` / 2, rounded down) × TRACK_LEN + `sector_pos`, combinationally from the current head position and sector input.
- R11: Without a strobe, `cur_phase` and `half_track` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_stb | input | 1 | One-cycle strobe marking a switch access |
| acc_addr | input | 4 | Low nibble of the switch address |
| online | input | 1 | Drive motor on; requests are dropped when low |
| sector_pos | input | SECT_W (13) | Byte position within the current track |
| half_track | output | POS_W (7) | Head position in half-tracks |
| cur_phase | output | 3 | Stored phase, 0 for none or 1 to 4 |
| img_offset | output | OFF_W (19) | Byte offset into the track-encoded image |

## Verification
`half_track` and `cur_phase` are due on the first rising edge after the strobe cycle. `img_offset` follows the current position and `sector_pos` with no clock delay. Reset release takes two further edges to reach the internal logic, and the bench idles through them before it sends a request. The bench drives every input just after a falling edge and advances its behavioural model by exactly one edge per drive. It compares all three outputs at the next falling edge, so the first comparison after a request lands one edge later, where both registered results are due.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int PH_W     = 3;
  localparam int NUM_COIL = 4;
  typedef logic [PH_W-1:0] phase_t;
  localparam phase_t PH_NONE = '0;
endpackage

// File: rtl/phase_req_decode.sv
module phase_req_decode
  import stp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              req_hit,
  output phase_t            req_phase
);
  logic [NUM_COIL-1:0] coil_sel;

  // coil k (1-based) is energised by address 2k-1
  for (genvar k = 0; k < NUM_COIL; k++) begin : g_coil
    assign coil_sel[k] = (addr == ADDR_W'(2*k + 1));
  end

  always_comb begin
    req_phase = PH_NONE;
    for (int k = 0; k < NUM_COIL; k++) begin
      if (coil_sel[k]) req_phase = phase_t'(k + 1);
    end
  end

  assign req_hit = |coil_sel;
endmodule

// File: rtl/phase_step_lut.sv
module phase_step_lut
  import stp_pkg::*;
(
  input  phase_t prev_ph,
  input  phase_t new_ph,
  output logic   step_up,
  output logic   step_dn
);
  logic [NUM_COIL-1:0] fwd_hit;
  logic [NUM_COIL-1:0] bwd_hit;

  for (genvar g = 1; g <= NUM_COIL; g++) begin : g_pair
    localparam int NEXT_C = (g % NUM_COIL) + 1;
    localparam int PREV_C = ((g + NUM_COIL - 2) % NUM_COIL) + 1;
    assign fwd_hit[g-1] = (prev_ph == phase_t'(g)) && (new_ph == phase_t'(NEXT_C));
    assign bwd_hit[g-1] = (prev_ph == phase_t'(g)) && (new_ph == phase_t'(PREV_C));
  end

  assign step_up = |fwd_hit;
  assign step_dn = |bwd_hit;
endmodule

// File: rtl/head_pos_reg.sv
module head_pos_reg #(
  parameter int NUM_HT = 70,
  localparam int POS_W  = $clog2(NUM_HT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             up,
  input  logic             dn,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(NUM_HT - 1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nxt;

  always_comb begin
    pos_nxt = pos_q;
    if (en && up && !dn) begin
      if (pos_q != POS_MAX) pos_nxt = pos_q + 1'b1;
    end else if (en && dn && !up) begin
      if (pos_q != '0) pos_nxt = pos_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pos_q <= '0;
    else if (en) pos_q <= pos_nxt;
  end

  assign pos = pos_q;

  // R9
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_MAX);

  // R8
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == '0 && dn && !up) |=> pos_q == '0);

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + 1'b1) ||
    (pos_q + 1'b1 == $past(pos_q)));
endmodule

// File: rtl/stepper_head_tracker.sv
module stepper_head_tracker
  import stp_pkg::*;
#(
  parameter int NUM_HT    = 70,
  parameter int TRACK_LEN = 6656,
  localparam int POS_W    = $clog2(NUM_HT),
  localparam int SECT_W   = $clog2(TRACK_LEN),
  localparam int OFF_W    = $clog2((NUM_HT / 2) * TRACK_LEN) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic [3:0]        acc_addr,
  input  logic              online,
  input  logic [SECT_W-1:0] sector_pos,
  output logic [POS_W-1:0]  half_track,
  output logic [PH_W-1:0]   cur_phase,
  output logic [OFF_W-1:0]  img_offset
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // request decode
  logic   req_hit;
  phase_t req_phase;

  phase_req_decode #(.ADDR_W(4)) u_dec (
    .addr      (acc_addr),
    .req_hit   (req_hit),
    .req_phase (req_phase)
  );

  logic take_req;
  assign take_req = acc_stb && online && req_hit;

  // stored phase
  phase_t ph_q;
  phase_t ph_nxt;

  always_comb begin
    ph_nxt = ph_q;
    if (take_req) ph_nxt = req_phase;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)      ph_q <= PH_NONE;
    else if (take_req) ph_q <= ph_nxt;
  end

  // step lookup
  logic step_up;
  logic step_dn;

  phase_step_lut u_lut (
    .prev_ph (ph_q),
    .new_ph  (req_phase),
    .step_up (step_up),
    .step_dn (step_dn)
  );

  // head position
  logic [POS_W-1:0] pos;

  head_pos_reg #(.NUM_HT(NUM_HT)) u_pos (
    .clk   (clk),
    .rst_n (rst_n_i),
    .en    (take_req),
    .up    (step_up),
    .dn    (step_dn),
    .pos   (pos)
  );

  // image offset
  logic [OFF_W-1:0] trk_idx;
  assign trk_idx    = OFF_W'(pos >> 1);
  assign img_offset = trk_idx * OFF_W'(TRACK_LEN) + OFF_W'(sector_pos);

  assign half_track = pos;
  assign cur_phase  = ph_q;

  // R2
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    cur_phase <= phase_t'(NUM_COIL));

  // R2
  phase_take_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (acc_stb && online && acc_addr[0] && !acc_addr[3]) |=>
      cur_phase == phase_t'({1'b0, $past(acc_addr[2:1])} + 3'd1));

  // R3
  off_addr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (acc_stb && (!acc_addr[0] || acc_addr[3])) |=>
      ($stable(cur_phase) && $stable(half_track)));

  // R4
  offline_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (acc_stb && !online) |=> ($stable(cur_phase) && $stable(half_track)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !acc_stb |=> ($stable(cur_phase) && $stable(half_track)));

  // R6
  no_dual_step_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0({step_up, step_dn}));
endmodule

// File: tb/stepper_head_tracker_bench.sv
`timescale 1ns/1ps
module stepper_head_tracker_bench;
  localparam int NUM_HT = 70;
  localparam int TL     = 6656;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_stb;
  logic [3:0]  acc_addr;
  logic        online;
  logic [12:0] sector_pos;
  logic [6:0]  half_track;
  logic [2:0]  cur_phase;
  logic [18:0] img_offset;

  always #4 clk = ~clk;

  stepper_head_tracker #(.NUM_HT(NUM_HT), .TRACK_LEN(TL)) u_stepper_head_tracker (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_addr(acc_addr),
    .online(online), .sector_pos(sector_pos), .half_track(half_track),
    .cur_phase(cur_phase), .img_offset(img_offset)
  );

  int    checks = 0;
  int    errors = 0;
  int    m_pos, m_ph, m_sect;
  string tag = "R1";
  bit    done = 0;

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(int'(half_track) == m_pos, tag, "half_track", int'(half_track), m_pos);
    chk(int'(cur_phase) == m_ph, (tag == "R3" || tag == "R4" || tag == "R11") ? tag : "R2",
        "cur_phase", int'(cur_phase), m_ph);
    chk(int'(img_offset) == (m_pos / 2) * TL + m_sect, "R10", "img_offset",
        int'(img_offset), (m_pos / 2) * TL + m_sect);
  endtask

  // one cycle: check what the last edge produced, then drive and advance the model
  task automatic cyc(input bit stb, input int a, input bit on, input int sect);
    int np, d, st, t;
    @(negedge clk);
    compare();
    acc_stb = stb; acc_addr = 4'(a); online = on; sector_pos = 13'(sect); m_sect = sect;
    if (!stb)                    tag = "R11";
    else if (!on)                tag = "R4";
    else if (a >= 8 || a % 2 == 0) tag = "R3";
    else begin
      np = (a - 1) / 2 + 1;
      d  = (np - m_ph + 4) % 4;
      st = 0;
      if (m_ph != 0) begin
        if (d == 1) st = 1;
        else if (d == 3) st = -1;
      end
      tag = (st == 1) ? "R5" : (st == -1) ? "R6" : "R7";
      t = m_pos + st;
      if (t < 0)          begin t = 0;          tag = "R8"; end
      if (t > NUM_HT - 1) begin t = NUM_HT - 1; tag = "R9"; end
      m_pos = t;
      m_ph  = np;
    end
  endtask

  task automatic req(input int ph);  // phase 1..4 -> address 2*ph-1
    cyc(1'b1, 2 * ph - 1, 1'b1, m_sect);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; acc_stb = 1'b0; acc_addr = '0; online = 1'b0;
    m_pos = 0; m_ph = 0; tag = "R1";
    repeat (3) @(negedge clk);
    chk(half_track == '0, "R1", "half_track in reset", int'(half_track), 0);
    chk(cur_phase == '0, "R1", "cur_phase in reset", int'(cur_phase), 0);
    rst_n = 1'b1;
    repeat (3) cyc(1'b0, 0, 1'b0, m_sect);
  endtask

  initial begin
    sector_pos = '0; m_sect = 0;
    do_reset();
    // first stated sequence: position 3 with phase 2, then phase 1
    req(1); req(3); req(4); req(1); req(2);
    cyc(1'b0, 0, 1'b1, 100);
    chk(half_track == 7'd3 && cur_phase == 3'd2, "R7", "setup pos3 ph2", int'(half_track), 3);
    req(1);
    cyc(1'b0, 0, 1'b1, 100);
    chk(half_track == 7'd2, "R6", "ph2->ph1 pos", int'(half_track), 2);
    chk(cur_phase == 3'd1, "R2", "ph2->ph1 phase", int'(cur_phase), 1);
    // floor clamp
    req(4); req(3); req(2); req(1); req(4); req(3);
    cyc(1'b0, 0, 1'b1, 5);
    chk(half_track == 7'd0, "R8", "floor clamp", int'(half_track), 0);
    // coil-off, out-of-range and offline accesses
    for (int a = 0; a < 16; a++) cyc(1'b1, a, 1'b0, a * 7);
    for (int a = 0; a < 16; a += 2) cyc(1'b1, a, 1'b1, a);
    for (int a = 9; a < 16; a += 2) cyc(1'b1, a, 1'b1, a);
    cyc(1'b0, 0, 1'b1, 0);
    chk(cur_phase == 3'd3 && half_track == 7'd0, "R4", "ignored accesses", int'(cur_phase), 3);
    // second stated sequence from phase 0
    do_reset();
    req(2); req(3); req(4); req(1); req(2); req(3);
    cyc(1'b0, 0, 1'b1, 0);
    chk(half_track == 7'd5 && cur_phase == 3'd3, "R7", "setup pos5 ph3", int'(half_track), 5);
    req(4);
    cyc(1'b0, 0, 1'b1, 0);
    chk(half_track == 7'd6, "R5", "ph3->ph4 pos", int'(half_track), 6);
    req(1);
    cyc(1'b0, 0, 1'b1, TL - 1);
    chk(half_track == 7'd7, "R5", "ph4->ph1 pos", int'(half_track), 7);
    cyc(1'b0, 0, 1'b1, TL - 1);
    chk(int'(img_offset) == 3 * TL + TL - 1, "R10", "offset at pos7", int'(img_offset), 4 * TL - 1);
    // ceiling clamp
    for (int i = 0; i < 90; i++) req((m_ph % 4) + 1);
    cyc(1'b0, 0, 1'b1, 17);
    chk(half_track == 7'(NUM_HT - 1), "R9", "ceiling clamp", int'(half_track), NUM_HT - 1);
    // random traffic
    for (int i = 0; i < 3000; i++)
      cyc(1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 15)),
          1'($urandom_range(0, 7) != 0), int'($urandom_range(0, TL - 1)));
    cyc(1'b0, 0, 1'b1, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule